// File: doc/BRIEF.md
# Host Interrupt Aggregator with Coalescing Timer

This block gathers single-cycle event pulses from around a device into one status word that the host reads, and drives a single interrupt line toward the host. Each status bit is set by its event and stays set until the host writes a 1 to it. A mask word chooses which status bits may interrupt. A second status word holds per-channel flags from the DMA engines. Several summary bits of the main word are derived from it, so the host sees a DMA channel event in the main word and clears it in the DMA word.

The interrupt line is not raised as soon as a masked bit becomes pending. A coalescing timer, counted in units of a slow tick, first lets further events accumulate. The tick nominally stands for 32 microseconds and is made by dividing the system clock. A high-priority receive flag in the DMA word skips that wait. A programmable periodic generator can also post its own status bit at a fixed number of ticks.

The host reaches four 32-bit words through a simple write strobe with an address, and a read data bus driven combinationally from the address. The word addresses are: 0 main status, 1 mask, 2 DMA status, 3 configuration. Configuration bits [7:0] hold the coalescing delay in ticks. Bits [15:8] hold the periodic interval in ticks.

Top module: `host_irq_aggregator`

## Requirements
- R1: After reset the main status, mask and DMA status words read 0, the configuration word reads 0x0000_0040, and `irq_out` is low.
- R2: A pulse on `evt_main` bit 0, 1, 3, 6, 7, 24, 25 or 26 sets the same bit of the main status word (address 0). Pulses on other `evt_main` bits are ignored. Writing 1 to a stored bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear wins. Stored bits never clear on their own.
- R3: A pulse on `evt_dma` bit 0, 1, 16, 17, 30 or 31 sets that bit of the DMA status word (address 2). Other bits are ignored. The host clears these bits by writing 1 to them.
- R4: Main bit 31 reads 1 when any of DMA bits 16, 17 or 30 is set. Main bit 27 reads 1 when DMA bit 0 or 1 is set. Main bit 29 mirrors DMA bit 31. Writing to these main bits has no effect.
- R5: The mask word (address 1) is read/write. `irq_out` is high only while (main status AND mask) is non-zero.
- R6: With delay D = config[7:0] non-zero, the timer starts one cycle after masked status first becomes non-zero. `irq_out` rises after the D-th tick that follows the start. With D = 0, `irq_out` rises one cycle after masked status becomes non-zero.
- R7: Once high, `irq_out` stays high until the host writes. When masked status returns to zero, the timer is cleared and the next masked event starts a full new delay.
- R8: While DMA bit 30 is set and mask bit 31 is set, `irq_out` is high regardless of the timer.
- R9: With P = config[15:8] non-zero, main status bit 28 is set once every P ticks. P = 0 stops it.
- R10: A tick occurs once every TICK_DIV clock cycles, running freely from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 2 | Word address: 0 status, 1 mask, 2 DMA status, 3 config |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| evt_main | input | 32 | Event pulses for the main status word |
| evt_dma | input | 32 | Event pulses for the DMA status word |
| irq_out | output | 1 | Host interrupt line |

## Verification
The bench drives several kinds of traffic:
- **Zero delay.** Separates the no-delay path from the counted path.
- **Short and long delays.** These show that the rise is held back by whole ticks and that the timer restarts after the host clears.
- **Masked-off events.** These must never raise the line.
- **Folded DMA patterns.** Receive, transmit and error flags are combined, with ignored bit positions among them. They show which summary bit each channel feeds and that summary bits cannot be cleared in the main word.
- **High-priority receive flag under a 255-tick delay.** This separates the bypass from an expired timer.
- **Periodic interval on, then off.** This shows the generator posts its bit and then stays silent.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned REG_W = 32;

    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_DMA  = 2'd2,
        ADDR_CFG  = 2'd3
    } reg_addr_e;

    // main status summary / periodic positions
    localparam int unsigned SUM_RX_POS   = 31;
    localparam int unsigned SUM_ERR_POS  = 29;
    localparam int unsigned PERIODIC_POS = 28;
    localparam int unsigned SUM_TX_POS   = 27;

    // DMA status positions
    localparam int unsigned DMA_TX0_POS = 0;
    localparam int unsigned DMA_TX1_POS = 1;
    localparam int unsigned DMA_RX0_POS = 16;
    localparam int unsigned DMA_RX1_POS = 17;
    localparam int unsigned DMA_HI_POS  = 30;
    localparam int unsigned DMA_ERR_POS = 31;

    // bits that events may set directly
    localparam logic [REG_W-1:0] MAIN_EVT_BITS = 32'h0700_00CB;
    localparam logic [REG_W-1:0] DMA_EVT_BITS  = 32'hC003_0003;

    localparam logic [15:0] CFG_RESET = 16'h0040;

endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int unsigned TICK_DIV = 6400
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t s_d, s_q;

    assign tick = (s_q.cnt == LAST);

    always_comb begin
        s_d = s_q;
        if (tick) s_d.cnt = '0;
        else      s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pending,
    input  logic [DLY_W-1:0] delay,
    output logic             expired
);
    typedef struct packed {
        logic             run;
        logic             exp;
        logic [DLY_W-1:0] cnt;
    } coal_state_t;

    coal_state_t s_d, s_q;

    assign expired = s_q.exp;

    always_comb begin
        s_d = s_q;
        if (!pending) begin
            s_d.run = 1'b0;
            s_d.exp = 1'b0;
            s_d.cnt = '0;
        end else if (s_q.exp) begin
            s_d = s_q;
        end else if (!s_q.run) begin
            if (delay == '0) begin
                s_d.exp = 1'b1;
            end else begin
                s_d.run = 1'b1;
                s_d.cnt = delay;
            end
        end else if (tick) begin
            if (s_q.cnt == DLY_W'(1)) begin
                s_d.exp = 1'b1;
                s_d.run = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_periodic.sv
module irq_periodic #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             fire
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } per_state_t;

    per_state_t s_d, s_q;

    assign fire = tick && (period != '0) && (s_q.cnt >= period - 1'b1);

    always_comb begin
        s_d = s_q;
        if (period == '0)  s_d.cnt = '0;
        else if (fire)     s_d.cnt = '0;
        else if (tick)     s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/host_irq_aggregator.sv
module host_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned TICK_DIV = 6400,
    parameter int unsigned DLY_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] evt_main,
    input  logic [31:0] evt_dma,
    output logic        irq_out
);
    localparam int unsigned CFG_W = 2 * DLY_W;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] dma;
        logic [CFG_W-1:0] cfg;
    } agg_state_t;

    agg_state_t s_d, s_q;

    logic             tick;
    logic             per_fire;
    logic             expired;
    logic             pending;
    logic             bypass;
    logic [REG_W-1:0] stat_view;
    logic [REG_W-1:0] per_bit;
    reg_addr_e        addr;

    assign addr = reg_addr_e'(reg_addr);

    irq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    irq_periodic #(.PER_W(DLY_W)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .period (s_q.cfg[CFG_W-1:DLY_W]),
        .fire   (per_fire)
    );

    irq_coal_timer #(.DLY_W(DLY_W)) u_coal (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pending (pending),
        .delay   (s_q.cfg[DLY_W-1:0]),
        .expired (expired)
    );

    // fold DMA channel flags into main summary bits
    always_comb begin
        stat_view = s_q.stat;
        stat_view[SUM_RX_POS]  = s_q.dma[DMA_RX0_POS] | s_q.dma[DMA_RX1_POS]
                               | s_q.dma[DMA_HI_POS];
        stat_view[SUM_TX_POS]  = s_q.dma[DMA_TX0_POS] | s_q.dma[DMA_TX1_POS];
        stat_view[SUM_ERR_POS] = s_q.dma[DMA_ERR_POS];
    end

    assign pending = |(stat_view & s_q.mask);
    assign bypass  = s_q.dma[DMA_HI_POS] & s_q.mask[SUM_RX_POS];
    assign irq_out = pending & (expired | bypass);

    always_comb begin
        per_bit = '0;
        per_bit[PERIODIC_POS] = per_fire;
    end

    always_comb begin
        s_d = s_q;
        s_d.stat = (s_q.stat & ~((reg_wr && addr == ADDR_STAT) ? reg_wdata : '0))
                 | (evt_main & MAIN_EVT_BITS) | per_bit;
        s_d.dma  = (s_q.dma & ~((reg_wr && addr == ADDR_DMA) ? reg_wdata : '0))
                 | (evt_dma & DMA_EVT_BITS);
        if (reg_wr && addr == ADDR_MASK) s_d.mask = reg_wdata;
        if (reg_wr && addr == ADDR_CFG)  s_d.cfg  = reg_wdata[CFG_W-1:0];
    end

    always_comb begin
        unique case (addr)
            ADDR_STAT: reg_rdata = stat_view;
            ADDR_MASK: reg_rdata = s_q.mask;
            ADDR_DMA:  reg_rdata = s_q.dma;
            default:   reg_rdata = {{(REG_W-CFG_W){1'b0}}, s_q.cfg};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.stat <= '0;
            s_q.mask <= '0;
            s_q.dma  <= '0;
            s_q.cfg  <= CFG_RESET[CFG_W-1:0];
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] evt_main,
    input logic        irq_out,
    input logic [31:0] stat_q,
    input logic [31:0] stat_view,
    input logic [31:0] mask_q,
    input logic [31:0] dma_q
);
    assert_irq_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((stat_view & mask_q) != 32'h0));

    assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=>
        ((stat_q & $past(reg_wdata) & ~$past(evt_main) & ~32'h1000_0000) == 32'h0));

    assert_no_spont_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd0) |=> (($past(stat_q) & ~stat_q) == 32'h0));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_q[30] && mask_q[31]) |-> irq_out);

    assert_hold_until_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !reg_wr) |=> irq_out);
endmodule

bind host_irq_aggregator irq_agg_checker u_irq_agg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt_main  (evt_main),
    .irq_out   (irq_out),
    .stat_q    (s_q.stat),
    .stat_view (stat_view),
    .mask_q    (s_q.mask),
    .dma_q     (s_q.dma)
);

// File: tb/host_irq_aggregator_bench.sv
`timescale 1ns/1ps
module host_irq_aggregator_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_main = '0;
    logic [31:0] evt_dma = '0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [31:0] m_st, m_mask, m_dma;
    logic [15:0] m_cfg;
    int          m_pc, m_per, m_cnt;
    bit          m_run, m_exp;

    always #2.5 clk = ~clk;

    host_irq_aggregator #(.TICK_DIV(DIV)) u_host_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_main(evt_main),
        .evt_dma(evt_dma), .irq_out(irq_out)
    );

    function automatic logic [31:0] m_view();
        logic [31:0] v;
        v = m_st;
        v[31] = m_dma[16] | m_dma[17] | m_dma[30];
        v[27] = m_dma[0] | m_dma[1];
        v[29] = m_dma[31];
        return v;
    endfunction

    function automatic bit m_irq();
        bit pend, byp;
        pend = (m_view() & m_mask) != 0;
        byp  = m_dma[30] && m_mask[31];
        return pend && (m_exp || byp);
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_view();
            2'd1: return m_mask;
            2'd2: return m_dma;
            default: return {16'h0, m_cfg};
        endcase
    endfunction

    task automatic m_reset();
        m_st = 0; m_mask = 0; m_dma = 0; m_cfg = 16'h0040;
        m_pc = 0; m_per = 0; m_cnt = 0; m_run = 0; m_exp = 0;
    endtask

    task automatic m_update();
        bit tick, pend, fire;
        int dly, per;
        logic [31:0] n_st, n_dma, pb;
        tick = (m_pc == DIV - 1);
        pend = (m_view() & m_mask) != 0;
        dly  = m_cfg[7:0];
        per  = m_cfg[15:8];
        fire = tick && per != 0 && m_per >= per - 1;
        pb = 0; pb[28] = fire;
        n_st  = (m_st & ~((reg_wr && reg_addr == 0) ? reg_wdata : 0))
              | (evt_main & 32'h0700_00CB) | pb;
        n_dma = (m_dma & ~((reg_wr && reg_addr == 2) ? reg_wdata : 0))
              | (evt_dma & 32'hC003_0003);
        if (!pend) begin m_run = 0; m_exp = 0; m_cnt = 0; end
        else if (m_exp) begin end
        else if (!m_run) begin
            if (dly == 0) m_exp = 1; else begin m_run = 1; m_cnt = dly; end
        end else if (tick) begin
            if (m_cnt == 1) begin m_exp = 1; m_run = 0; end
            else m_cnt = m_cnt - 1;
        end
        if (per == 0) m_per = 0;
        else if (fire) m_per = 0;
        else if (tick) m_per = m_per + 1;
        m_pc = tick ? 0 : m_pc + 1;
        if (reg_wr && reg_addr == 1) m_mask = reg_wdata;
        if (reg_wr && reg_addr == 3) m_cfg = reg_wdata[15:0];
        m_st = n_st; m_dma = n_dma;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic w, input logic [1:0] a,
                        input logic [31:0] wd, input logic [31:0] em, input logic [31:0] ed);
        reg_wr = w; reg_addr = a; reg_wdata = wd; evt_main = em; evt_dma = ed;
        @(posedge clk);
        m_update();
        @(negedge clk);
        reg_wr = 0; evt_main = 0; evt_dma = 0;
        chk({tag, " irq model"}, {31'h0, irq_out}, {31'h0, m_irq()});
        chk({tag, " rdata model"}, reg_rdata, m_read(reg_addr));
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 2'd0, 0, 0, 0);
    endtask

    task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
        step(tag, 1, a, d, 0, 0);
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        step(tag, 0, a, 0, 0, 0);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 irq", {31'h0, irq_out}, 32'h0);
        rd("R1 status", 2'd0, 32'h0);
        rd("R1 mask", 2'd1, 32'h0);
        rd("R1 dma", 2'd2, 32'h0);
        rd("R1 cfg", 2'd3, 32'h0000_0040);

        // R5 mask read/write, R6 zero delay
        wr("R5 mask", 2'd1, 32'hFFFF_FFFF);
        rd("R5 mask rd", 2'd1, 32'hFFFF_FFFF);
        wr("R6 cfg0", 2'd3, 32'h0);
        step("R2 evt3", 0, 2'd0, 0, 32'h8, 0);
        chk("R6 not yet", {31'h0, irq_out}, 32'h0);
        rd("R2 set", 2'd0, 32'h8);
        chk("R6 zero delay", {31'h0, irq_out}, 32'h1);

        // R2 write-one-to-clear
        wr("R2 wr0", 2'd0, 32'h0);
        rd("R2 keep", 2'd0, 32'h8);
        wr("R2 wr1", 2'd0, 32'h8);
        rd("R2 clear", 2'd0, 32'h0);
        chk("R7 drop", {31'h0, irq_out}, 32'h0);
        step("R2 ign", 0, 2'd0, 0, 32'h0000_0400, 0);
        rd("R2 ignored", 2'd0, 32'h0);
        step("R2 race", 1, 2'd0, 32'h80, 32'h80, 0);
        rd("R2 event wins", 2'd0, 32'h80);
        wr("R2 clr7", 2'd0, 32'h80);

        // R5 masked off
        wr("R5 mask0", 2'd1, 32'h0);
        step("R5 evt0", 0, 2'd0, 0, 32'h1, 0);
        idle("R5 masked", 10);
        chk("R5 no irq", {31'h0, irq_out}, 32'h0);
        rd("R5 stat", 2'd0, 32'h1);
        wr("R5 clr", 2'd0, 32'h1);
        wr("R5 maskall", 2'd1, 32'hFFFF_FFFF);

        // R6 delay of 3 ticks
        wr("R6 cfg3", 2'd3, 32'h3);
        step("R6 evt25", 0, 2'd0, 0, 32'h0200_0000, 0);
        idle("R6 wait", 2);
        chk("R6 held", {31'h0, irq_out}, 32'h0);
        idle("R6 run", 20);
        chk("R6 expired", {31'h0, irq_out}, 32'h1);
        wr("R7 clear", 2'd0, 32'h0200_0000);
        chk("R7 low", {31'h0, irq_out}, 32'h0);
        step("R7 evt6", 0, 2'd0, 0, 32'h40, 0);
        idle("R7 restart", 2);
        chk("R7 restarted", {31'h0, irq_out}, 32'h0);
        idle("R7 run", 20);
        chk("R7 expired", {31'h0, irq_out}, 32'h1);
        wr("R7 clr", 2'd0, 32'h40);

        // R10 one-tick delay lands within DIV+1 cycles
        wr("R10 cfg1", 2'd3, 32'h1);
        step("R10 evt1", 0, 2'd0, 0, 32'h2, 0);
        idle("R10 wait", DIV + 1);
        chk("R10 tick", {31'h0, irq_out}, 32'h1);
        wr("R10 clr", 2'd0, 32'h2);

        // R3 / R4 DMA folding
        wr("R3 cfgFF", 2'd3, 32'hFF);
        step("R3 rx0", 0, 2'd0, 0, 0, 32'h0001_0000);
        rd("R3 dma", 2'd2, 32'h0001_0000);
        rd("R4 rx sum", 2'd0, 32'h8000_0000);
        chk("R6 long delay", {31'h0, irq_out}, 32'h0);
        wr("R4 wr sum", 2'd0, 32'h8000_0000);
        rd("R4 no effect", 2'd0, 32'h8000_0000);
        step("R3 mix", 0, 2'd0, 0, 0, 32'h8000_0022);
        rd("R3 dma mix", 2'd2, 32'h8001_0002);
        rd("R4 sums", 2'd0, 32'hA800_0000);
        wr("R3 clr", 2'd2, 32'h8001_0002);
        rd("R3 cleared", 2'd2, 32'h0);
        rd("R4 cleared", 2'd0, 32'h0);

        // R8 bypass
        step("R8 hi", 0, 2'd0, 0, 0, 32'h4000_0000);
        chk("R8 bypass", {31'h0, irq_out}, 32'h1);
        rd("R8 sum", 2'd0, 32'h8000_0000);
        wr("R8 clr", 2'd2, 32'h4000_0000);
        chk("R8 low", {31'h0, irq_out}, 32'h0);

        // R9 periodic
        wr("R9 mask", 2'd1, 32'h1000_0000);
        wr("R9 cfg", 2'd3, 32'h0300);
        idle("R9 run", 40);
        rd("R9 posted", 2'd0, 32'h1000_0000);
        chk("R9 irq", {31'h0, irq_out}, 32'h1);
        wr("R9 off", 2'd3, 32'h0);
        wr("R9 clr", 2'd0, 32'h1000_0000);
        idle("R9 quiet", 30);
        rd("R9 disabled", 2'd0, 32'h0);
        chk("R9 no irq", {31'h0, irq_out}, 32'h0);

        summary();
    end
endmodule